// File: doc/BRIEF.md
# Off-Hook Loop Closure Detector

This block decides whether a subscriber line has gone off-hook. On every sample strobe it takes an 8-bit loop-current sample or an 8-bit loop-voltage sample, whichever the mode bit selects. It smooths that sample with a first-order low-pass filter and compares the smoothed level with one threshold, or with two thresholds when hysteresis is on. The comparator result then has to persist for a programmable number of samples before the status output changes.

Processing only takes place while the linefeed-state code reports one of the two on-hook listening states. In every other state the filter, the debounce counter and the status hold their values. Each change of the status can raise a sticky pending flag, gated by an enable. A one-cycle clear pulse removes the flag.

Top module: `loop_close_det`

## Requirements
- R1: After reset `closed` is 0, `irq_pend` is 0, and the filter accumulator and the debounce counter are 0.
- R2: A sample is processed only in a cycle where `smp_vld` is 1 and `line_state` is 3'd1 (on-hook active) or 3'd2 (on-hook transmission). For every other code, or when `smp_vld` is 0, the filter, the counter and `closed` keep their values.
- R3: When `volt_mode` is 1 the detector input is `vol_smp`. When it is 0 the input is `cur_smp`.
- R4: The filter keeps a 21-bit accumulator with 13 fractional bits. Each processed sample updates it as acc += ((x·2^13 − acc)·`flt_coef`) >>> 13, using signed arithmetic that rounds toward minus infinity. The compared level is accumulator bits [20:15], which are the top 6 bits of the 8-bit filtered value.
- R5: In current mode without hysteresis, the comparator reports closure when level > `thr_hi`.
- R6: In voltage mode without hysteresis, the comparator reports closure when level < `thr_hi`.
- R7: With `hyst_en` = 1, the debounced state `closed` picks the bound. In current mode the comparator reports closure when level > `thr_hi` while open, and when level > `thr_lo` while closed. In voltage mode it reports closure when level < `thr_lo` while open, and when level < `thr_hi` while closed.
- R8: With interval N = `dbnc_len`, `closed` changes on the (N+1)-th consecutive processed sample whose comparator result differs from `closed`. A processed sample that agrees with `closed` resets the count to 0.
- R9: With `dbnc_len` = 0, `closed` takes the comparator result on the same processed sample, visible after that clock edge.
- R10: Each change of `closed` sets `irq_pend` when `irq_en` is 1. A change while `irq_en` is 0 leaves `irq_pend` as it was.
- R11: `irq_pend` stays set until a cycle with `irq_clr` = 1. A change of `closed` that sets it in that same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe |
| cur_smp | input | 8 | Loop-current sample |
| vol_smp | input | 8 | Loop-voltage sample |
| line_state | input | 3 | Linefeed-state code |
| volt_mode | input | 1 | 1 selects voltage detection |
| hyst_en | input | 1 | Enables the two-bound hysteresis |
| flt_coef | input | 13 | Low-pass coefficient (Q0.13) |
| thr_hi | input | 6 | Upper threshold |
| thr_lo | input | 6 | Lower threshold |
| dbnc_len | input | 7 | Debounce interval in samples |
| irq_en | input | 1 | Enables raising of the pending flag |
| irq_clr | input | 1 | One-cycle clear of the pending flag |
| closed | output | 1 | Debounced loop-closure status |
| irq_pend | output | 1 | Sticky pending flag |

## Verification
Two things can happen in the same clock edge: a debounced status change that raises the pending flag, and the clear pulse that removes it. The bench provokes this with interval 0 and a large swing in the sample. That sample flips the status and is presented together with `irq_clr`. The flag must read 1 after the edge, and a later clear alone must bring it to 0. Random traffic repeats the collision many times, and a bench reference model judges every cycle.

// File: rtl/loop_close_det.sv
module loop_close_det #(
  parameter int SW = 8,
  parameter int CW = 13,
  parameter int TW = 6,
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [SW-1:0] cur_smp,
  input  logic [SW-1:0] vol_smp,
  input  logic [2:0]    line_state,
  input  logic          volt_mode,
  input  logic          hyst_en,
  input  logic [CW-1:0] flt_coef,
  input  logic [TW-1:0] thr_hi,
  input  logic [TW-1:0] thr_lo,
  input  logic [DW-1:0] dbnc_len,
  input  logic          irq_en,
  input  logic          irq_clr,
  output logic          closed,
  output logic          irq_pend
);
  localparam int AW = SW + CW;
  localparam int PW = AW + 1 + CW + 1;

  logic [AW-1:0] acc, acc_nx;
  logic [DW-1:0] cnt;
  logic [SW-1:0] x;
  logic signed [AW:0]   diff;
  logic signed [PW-1:0] prod;
  logic signed [AW+1:0] sum;
  logic [TW-1:0] lvl;
  logic proc, cmp, flip;

  assign proc = smp_vld && (line_state == 3'd1 || line_state == 3'd2);
  assign x    = volt_mode ? vol_smp : cur_smp;
  assign diff = $signed({1'b0, x, {CW{1'b0}}}) - $signed({1'b0, acc});
  assign prod = diff * $signed({1'b0, flt_coef});
  assign sum  = $signed({2'b00, acc}) + $signed(prod[PW-1:CW]);
  assign acc_nx = sum[AW-1:0];
  assign lvl  = acc_nx[AW-1:AW-TW];

  always_comb begin
    if (!volt_mode)
      cmp = (hyst_en && closed) ? (lvl > thr_lo) : (lvl > thr_hi);
    else if (hyst_en)
      cmp = closed ? (lvl < thr_hi) : (lvl < thr_lo);
    else
      cmp = lvl < thr_hi;
  end

  assign flip = proc && (cmp != closed) && (cnt >= dbnc_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
      closed <= 1'b0;
    end else if (proc) begin
      acc <= acc_nx;
      if (cmp == closed || flip) cnt <= '0;
      else cnt <= cnt + 1'b1;
      if (flip) closed <= cmp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_pend <= 1'b0;
    else if (flip && irq_en) irq_pend <= 1'b1;
    else if (irq_clr) irq_pend <= 1'b0;
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !proc |=> $stable(closed) && $stable(acc) && $stable(cnt));
  // R8
  agree_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc && cmp == closed) |=> cnt == '0 && $stable(closed));
  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (closed != $past(closed) && $past(irq_en)) |-> irq_pend);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(irq_en) && closed != $past(closed));
  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_clr) |=> irq_pend);
endmodule

// File: tb/loop_close_det_bench.sv
module loop_close_det_bench;
  logic clk = 0, rst_n = 0, smp_vld = 0;
  logic [7:0] cur_smp = 0, vol_smp = 0;
  logic [2:0] line_state = 0;
  logic volt_mode = 0, hyst_en = 0, irq_en = 0, irq_clr = 0;
  logic [12:0] flt_coef = 0;
  logic [5:0] thr_hi = 0, thr_lo = 0;
  logic [6:0] dbnc_len = 0;
  logic closed, irq_pend;

  int checks = 0, failures = 0;
  longint m_acc = 0;
  int m_cnt = 0;
  bit m_closed = 0, m_irq = 0;

  always #2 clk = ~clk;

  loop_close_det u_loop_close_det (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .cur_smp(cur_smp), .vol_smp(vol_smp),
    .line_state(line_state), .volt_mode(volt_mode), .hyst_en(hyst_en), .flt_coef(flt_coef),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .dbnc_len(dbnc_len), .irq_en(irq_en), .irq_clr(irq_clr),
    .closed(closed), .irq_pend(irq_pend));

  function automatic bit cmp_f(longint lvl, bit cl);
    if (!volt_mode) return (hyst_en && cl) ? (lvl > thr_lo) : (lvl > thr_hi);
    if (hyst_en) return cl ? (lvl < thr_hi) : (lvl < thr_lo);
    return lvl < thr_hi;
  endfunction

  task automatic model_next();
    bit flip = 0;
    if (smp_vld && (line_state == 3'd1 || line_state == 3'd2)) begin
      longint x = volt_mode ? longint'(vol_smp) : longint'(cur_smp);
      longint d = (x <<< 13) - m_acc;
      bit c;
      m_acc = m_acc + ((d * longint'(flt_coef)) >>> 13);
      c = cmp_f(m_acc >>> 15, m_closed);
      if (c == m_closed) m_cnt = 0;
      else if (m_cnt >= int'(dbnc_len)) begin flip = 1; m_closed = c; m_cnt = 0; end
      else m_cnt++;
    end
    if (flip && irq_en) m_irq = 1;
    else if (irq_clr) m_irq = 0;
  endtask

  task automatic chk(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    model_next();
    @(posedge clk); #1;
    chk(tag, "closed", closed, m_closed);
    chk(tag, "irq_pend", irq_pend, m_irq);
  endtask

  task automatic cfg(bit vm, bit hy, int coef, int hi, int lo, int len, bit ie);
    volt_mode = vm; hyst_en = hy; flt_coef = 13'(coef); thr_hi = 6'(hi);
    thr_lo = 6'(lo); dbnc_len = 7'(len); irq_en = ie;
  endtask

  task automatic smp(int v, string tag);
    smp_vld = 1; cur_smp = 8'(v); vol_smp = 8'(v); step(tag); smp_vld = 0;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "closed", closed, 0);
    chk("R1", "irq_pend", irq_pend, 0);
    rst_n = 1;
    line_state = 3'd1;
    // R9 + R5: immediate follow, current mode
    cfg(0, 0, 8191, 20, 0, 0, 1);
    smp(255, "R9");
    chk("R9", "closed_direct", closed, 1);
    // R11: clear alone
    irq_clr = 1; step("R11"); irq_clr = 0;
    chk("R11", "cleared", irq_pend, 0);
    // R11: event and clear in one cycle
    irq_clr = 1; smp(0, "R11"); irq_clr = 0;
    chk("R11", "event_wins", irq_pend, 1);
    irq_clr = 1; step("R11"); irq_clr = 0;
    // R10: change with irq disabled
    irq_en = 0; smp(255, "R10");
    chk("R10", "no_irq", irq_pend, 0);
    // R2: inactive states hold
    for (int s = 0; s < 8; s++) begin
      if (s == 1 || s == 2) continue;
      line_state = 3'(s); smp(0, "R2");
      chk("R2", "hold", closed, 1);
    end
    line_state = 3'd2;
    // R8: debounce 3, interrupted run restarts
    cfg(0, 0, 8191, 20, 0, 3, 1);
    smp(0, "R8"); smp(0, "R8"); smp(0, "R8"); smp(255, "R8");
    smp(0, "R8"); smp(0, "R8"); smp(0, "R8");
    chk("R8", "still_closed", closed, 1);
    smp(0, "R8");
    chk("R8", "opened", closed, 0);
    // R3 + R6: voltage mode, current sample ignored
    cfg(1, 0, 8191, 30, 0, 0, 1);
    smp_vld = 1; vol_smp = 255; cur_smp = 0; step("R3"); smp_vld = 0;
    chk("R3", "volt_high_open", closed, 0);
    smp_vld = 1; vol_smp = 10; cur_smp = 255; step("R6"); smp_vld = 0;
    chk("R6", "volt_low_closed", closed, 1);
    // R7: hysteresis, current mode
    cfg(0, 1, 8191, 40, 10, 0, 0);
    smp(0, "R7");
    smp(255, "R7");
    smp(100, "R7");
    chk("R7", "above_lo_stays", closed, 1);
    smp(30, "R7");
    chk("R7", "below_lo_opens", closed, 0);
    smp(100, "R7");
    chk("R7", "below_hi_stays_open", closed, 0);
    cfg(1, 1, 8191, 40, 10, 0, 0);
    smp(100, "R7"); smp(120, "R7"); smp(255, "R7"); smp(20, "R7"); smp(150, "R7");
    // R4: slow filter staircase
    cfg(0, 0, 1024, 25, 0, 0, 1);
    for (int i = 0; i < 40; i++) smp(255, "R4");
    for (int i = 0; i < 40; i++) smp(0, "R4");
    // random traffic
    for (int blk = 0; blk < 20; blk++) begin
      cfg($urandom % 2, $urandom % 2, ($urandom % 4 == 0) ? 8191 : $urandom % 8192,
          $urandom % 64, $urandom % 64, $urandom % 5, $urandom % 2);
      for (int i = 0; i < 200; i++) begin
        smp_vld = ($urandom % 4) != 0;
        line_state = 3'($urandom % 4);
        cur_smp = 8'($urandom); vol_smp = 8'($urandom);
        irq_clr = ($urandom % 6) == 0;
        step("R4");
      end
    end
    smp_vld = 0; irq_clr = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule